// File: doc/BRIEF.md
# Programmable Chip-Select Generator

This block decodes a 24-bit bus cycle against a set of programmable channels and drives one active-low select line per channel. Each channel carries a base word, which holds an address and a region-size code, plus an option word. The option word limits the match by byte lane, transfer direction and address space. In CPU space it also limits the match by interrupt-acknowledge level. It further chooses whether the select follows the address strobe or the data strobe, and how the cycle is terminated.

While a cycle runs, the block counts clock edges from the first edge that sees the address strobe. When the count reaches the programmed wait, the block issues a one-cycle termination pulse. The pulse also reports the port width, 8 or 16 bits, from the channel's pin code. A matching interrupt-acknowledge cycle can request an autovector in place of the normal acknowledge. The channel configuration arrives on static input vectors. Channel `i` occupies slice `i` of each vector.

Top module: `cs_select_unit`

## Requirements
- R1: While `rst` is high, every `cs_n` bit is 1 and `ack`, `ack_wide` and `autovec` are 0 on the following edge.
- R2: Base word bits 15:3 hold address bits 23:11 and bits 2:0 hold the size code (0=2K, 1=8K, 2=16K, 3=64K, 4=128K, 5=256K, 6=512K, 7=1M bytes). Only the address bits above the region size are compared.
- R3: Option bits 14:13 select lanes: 00 none, 01 lower, 10 upper, 11 either. A channel matches only if a lane it allows is active (`lane_lo`, `lane_hi`).
- R4: Option bits 12:11 set direction. Bit 11 allows reads (`bus_read`=1) and bit 12 allows writes. 01 is read only, 10 is write only and 11 is both.
- R5: Option bits 5:4 give the space: 00 CPU, 01 user, 10 supervisor, 11 user or supervisor. These are compared with `bus_space`, which uses 00 CPU, 01 user and 10 supervisor.
- R6: In CPU space, option bits 3:1 must be 0, which accepts any level, or equal `iack_level`. The level is not checked in the other spaces.
- R7: Option bit 10 chooses the strobe. At 0, `cs_n[i]` goes low one edge after `addr_strobe` is seen with a match. At 1, it goes low one edge after `data_strobe` is seen.
- R8: Only pin codes 10 and 11 make a channel a chip select. Codes 00 and 01 keep its `cs_n` high and let it produce no termination.
- R9: Option bits 9:6 set the termination. A value n from 0 to 13 pulses `ack` on edge n+2 of the cycle, counting the first edge that sees `addr_strobe` as edge 1. A value of 14 pulses it on edge 1. A value of 15 produces no pulse.
- R10: `ack_wide` is 1 with the pulse when the terminating channel's pin code is 11 (16-bit port), and 0 for code 10.
- R11: If option bit 0 is set and the match is in CPU space, `autovec` pulses at the time `ack` would have, and `ack` stays low.
- R12: When several channels match, all of them drive their selects, but the termination follows the lowest-numbered one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | N_CH*16 | Base words, channel i at bits [16i+15:16i] |
| cfg_opt | input | N_CH*15 | Option words, channel i at bits [15i+14:15i] |
| cfg_pin | input | N_CH*2 | Pin codes, channel i at bits [2i+1:2i] |
| bus_addr | input | 13 | Address bits 23:11 of the cycle |
| bus_read | input | 1 | 1 = read, 0 = write |
| lane_hi | input | 1 | Upper byte lane active |
| lane_lo | input | 1 | Lower byte lane active |
| bus_space | input | 2 | Cycle space: 00 CPU, 01 user, 10 supervisor |
| iack_level | input | 3 | Level being acknowledged in CPU space |
| addr_strobe | input | 1 | Address strobe, active high |
| data_strobe | input | 1 | Data strobe, active high |
| cs_n | output | N_CH | Active-low selects |
| ack | output | 1 | One-cycle termination pulse |
| ack_wide | output | 1 | Port width with the pulse: 1 = 16-bit |
| autovec | output | 1 | One-cycle autovector pulse |

## Verification
A corrupted wait counter or a wrong priority pick shows at the ports as a termination pulse on the wrong edge, or with the wrong width. The mistake appears within the first 15 edges of the cycle in which it happens. A wrong mask width in the compare shows as a select that asserts, or fails to assert, on an address just past the region boundary, one edge after the strobe. The bench therefore records, for each bus cycle, the select pattern on edges 1 and 2 and the edge of each pulse, and compares these against an expected item queued for that cycle.

// File: rtl/cs_pkg.sv
`timescale 1ns/1ps
package cs_pkg;
  localparam int BLK_LG_MIN = 11;   // smallest region: 2K bytes
  localparam int TERM_W     = 4;
  localparam logic [TERM_W-1:0] TERM_FAST = 4'd14;
  localparam logic [TERM_W-1:0] TERM_EXT  = 4'd15;
  localparam int OPT_W      = 15;

  typedef enum logic [1:0] {
    SP_CPU   = 2'b00,
    SP_USER  = 2'b01,
    SP_SUPER = 2'b10,
    SP_BOTH  = 2'b11
  } space_e;

  typedef struct packed {
    logic [1:0]        lanes;    // 14:13
    logic [1:0]        dir;      // 12:11 (bit 11 read, bit 12 write)
    logic              ds_sync;  // 10
    logic [TERM_W-1:0] term;     // 9:6
    logic [1:0]        space;    // 5:4
    logic [2:0]        level;    // 3:1
    logic              avec;     // 0
  } cs_opt_t;

  // number of compared base bits masked off for a size code
  function automatic int blk_ignore(input logic [2:0] code);
    case (code)
      3'd0:    return 0;
      3'd1:    return 2;
      3'd2:    return 3;
      3'd3:    return 5;
      default: return int'(code) + 2;
    endcase
  endfunction
endpackage

// File: rtl/cs_chan_decode.sv
`timescale 1ns/1ps
module cs_chan_decode
  import cs_pkg::*;
#(
  parameter int ADDR_W = 24,
  localparam int CMP_W  = ADDR_W - BLK_LG_MIN,
  localparam int BASE_W = CMP_W + 3
) (
  input  logic [BASE_W-1:0]          base_i,
  input  logic [1:0]                 lanes_i,
  input  logic [1:0]                 dir_i,
  input  logic [1:0]                 space_sel_i,
  input  logic [2:0]                 level_sel_i,
  input  logic                       cs_en_i,
  input  logic [ADDR_W-1:BLK_LG_MIN] addr_i,
  input  logic                       read_i,
  input  logic                       lane_hi_i,
  input  logic                       lane_lo_i,
  input  logic [1:0]                 space_i,
  input  logic [2:0]                 level_i,
  output logic                       hit_o,
  output logic                       iack_o
);
  logic [CMP_W-1:0] diff;
  logic addr_ok, lane_ok, dir_ok, sp_ok, lvl_ok;
  int   ign;

  always_comb begin
    ign  = blk_ignore(base_i[2:0]);
    diff = '0;
    for (int b = 0; b < CMP_W; b++) begin
      if (b >= ign) diff[b] = addr_i[b + BLK_LG_MIN] ^ base_i[b + 3];
    end
  end

  assign iack_o  = (space_i == SP_CPU);
  assign addr_ok = ~|diff;
  assign lane_ok = |(lanes_i & {lane_hi_i, lane_lo_i});
  assign dir_ok  = read_i ? dir_i[0] : dir_i[1];
  assign sp_ok   = iack_o ? (space_sel_i == SP_CPU)
                          : ((space_sel_i == space_i) || (space_sel_i == SP_BOTH));
  assign lvl_ok  = !iack_o || (level_sel_i == 3'd0) || (level_sel_i == level_i);
  assign hit_o   = cs_en_i && addr_ok && lane_ok && dir_ok && sp_ok && lvl_ok;
endmodule

// File: rtl/cs_term_ctrl.sv
`timescale 1ns/1ps
module cs_term_ctrl
  import cs_pkg::*;
#(
  parameter int N_CH = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     strobe_i,
  input  logic [N_CH-1:0]          hit_i,
  input  logic [N_CH*TERM_W-1:0]   term_i,
  input  logic [N_CH-1:0]          wide_i,
  input  logic [N_CH-1:0]          avec_i,
  output logic                     ack_o,
  output logic                     wide_o,
  output logic                     avec_o
);
  logic              any_hit, w_wide, w_avec, fire;
  logic [TERM_W-1:0] w_term, tgt, cnt;

  // lowest index wins: scan downwards so it overrides last
  always_comb begin
    any_hit = 1'b0;
    w_term  = '0;
    w_wide  = 1'b0;
    w_avec  = 1'b0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        any_hit = 1'b1;
        w_term  = term_i[i*TERM_W +: TERM_W];
        w_wide  = wide_i[i];
        w_avec  = avec_i[i];
      end
    end
  end

  assign tgt  = (w_term == TERM_FAST) ? '0 : w_term + 1'b1;
  assign fire = any_hit && (w_term != TERM_EXT) && (cnt == tgt);

  always_ff @(posedge clk) begin
    if (rst || !strobe_i) begin
      cnt    <= '0;
      ack_o  <= 1'b0;
      wide_o <= 1'b0;
      avec_o <= 1'b0;
    end else begin
      cnt    <= (&cnt) ? cnt : cnt + 1'b1;
      ack_o  <= fire && !w_avec;
      avec_o <= fire && w_avec;
      wide_o <= fire && w_wide;
    end
  end
endmodule

// File: rtl/cs_select_unit.sv
`timescale 1ns/1ps
module cs_select_unit
  import cs_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int ADDR_W = 24
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [N_CH*(ADDR_W-8)-1:0]        cfg_base,
  input  logic [N_CH*15-1:0]                cfg_opt,
  input  logic [N_CH*2-1:0]                 cfg_pin,
  input  logic [ADDR_W-1:11]                bus_addr,
  input  logic                              bus_read,
  input  logic                              lane_hi,
  input  logic                              lane_lo,
  input  logic [1:0]                        bus_space,
  input  logic [2:0]                        iack_level,
  input  logic                              addr_strobe,
  input  logic                              data_strobe,
  output logic [N_CH-1:0]                   cs_n,
  output logic                              ack,
  output logic                              ack_wide,
  output logic                              autovec
);
  localparam int BASE_W = ADDR_W - BLK_LG_MIN + 3;

  logic [N_CH-1:0]        hit, wide, avec_req;
  logic [N_CH*TERM_W-1:0] terms;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    cs_opt_t opt;
    logic    iack;
    assign opt = cs_opt_t'(cfg_opt[i*OPT_W +: OPT_W]);

    cs_chan_decode #(.ADDR_W(ADDR_W)) u_dec (
      .base_i      (cfg_base[i*BASE_W +: BASE_W]),
      .lanes_i     (opt.lanes),
      .dir_i       (opt.dir),
      .space_sel_i (opt.space),
      .level_sel_i (opt.level),
      .cs_en_i     (cfg_pin[2*i+1]),
      .addr_i      (bus_addr),
      .read_i      (bus_read),
      .lane_hi_i   (lane_hi),
      .lane_lo_i   (lane_lo),
      .space_i     (bus_space),
      .level_i     (iack_level),
      .hit_o       (hit[i]),
      .iack_o      (iack)
    );

    assign wide[i]                   = cfg_pin[2*i];
    assign avec_req[i]               = opt.avec && iack;
    assign terms[i*TERM_W +: TERM_W] = opt.term;

    always_ff @(posedge clk) begin
      if (rst) cs_n[i] <= 1'b1;
      else     cs_n[i] <= !(hit[i] && (opt.ds_sync ? data_strobe : addr_strobe));
    end
  end

  cs_term_ctrl #(.N_CH(N_CH)) u_term (
    .clk      (clk),
    .rst      (rst),
    .strobe_i (addr_strobe),
    .hit_i    (hit),
    .term_i   (terms),
    .wide_i   (wide),
    .avec_i   (avec_req),
    .ack_o    (ack),
    .wide_o   (ack_wide),
    .avec_o   (autovec)
  );
endmodule

// File: rtl/cs_select_unit_chk.sv
`timescale 1ns/1ps
module cs_select_unit_chk #(
  parameter int N_CH = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            addr_strobe,
  input logic            data_strobe,
  input logic [N_CH-1:0] cs_n,
  input logic            ack,
  input logic            autovec
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (&cs_n && !ack && !autovec));

  p_one_term_r11: assert property (@(posedge clk) disable iff (rst)
    !(ack && autovec));

  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  p_avec_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    autovec |=> !autovec);

  p_cs_needs_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    !(&cs_n) |-> $past(addr_strobe || data_strobe));

  p_term_needs_as_r9: assert property (@(posedge clk) disable iff (rst)
    (ack || autovec) |-> $past(addr_strobe));
endmodule

bind cs_select_unit cs_select_unit_chk #(.N_CH(N_CH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .addr_strobe (addr_strobe),
  .data_strobe (data_strobe),
  .cs_n        (cs_n),
  .ack         (ack),
  .autovec     (autovec)
);

// File: tb/test_cs_select_unit.sv
`timescale 1ns/1ps
module test_cs_select_unit;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [15:0] b [N];
  logic [14:0] o [N];
  logic [1:0]  p [N];
  logic [N*16-1:0] cfg_base;
  logic [N*15-1:0] cfg_opt;
  logic [N*2-1:0]  cfg_pin;
  always_comb for (int i = 0; i < N; i++) begin
    cfg_base[i*16 +: 16] = b[i];
    cfg_opt[i*15 +: 15]  = o[i];
    cfg_pin[i*2 +: 2]    = p[i];
  end

  logic [23:0] addr = '0;
  logic rd = 1'b1, hi = 1'b0, lo = 1'b0, as_s = 1'b0, ds_s = 1'b0;
  logic [1:0] sp = 2'b01;
  logic [2:0] lvl = 3'd0;
  logic [N-1:0] cs_n;
  logic ack, ack_wide, autovec;

  cs_select_unit #(.N_CH(N), .ADDR_W(24)) i_cs_select_unit (
    .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_opt(cfg_opt), .cfg_pin(cfg_pin),
    .bus_addr(addr[23:11]), .bus_read(rd), .lane_hi(hi), .lane_lo(lo),
    .bus_space(sp), .iack_level(lvl), .addr_strobe(as_s), .data_strobe(ds_s),
    .cs_n(cs_n), .ack(ack), .ack_wide(ack_wide), .autovec(autovec));

  typedef struct {
    logic [N-1:0] cs1;
    logic [N-1:0] cs2;
    int           ack_at;
    int           av_at;
    logic         wide;
    string        tag;
  } exp_t;
  exp_t sb_q[$];

  int checks = 0, errors = 0;

  task automatic check(input logic ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // driver: queue the expectation, then run an 18-edge bus cycle
  task automatic run_cycle(input logic [23:0] a, input logic r, input logic h,
      input logic l, input logic [1:0] s, input logic [2:0] lv, input logic ds_late,
      input logic [N-1:0] e1, input logic [N-1:0] e2, input int e_ack,
      input int e_av, input logic e_wide, input string tag);
    exp_t e;
    e.cs1 = e1; e.cs2 = e2; e.ack_at = e_ack; e.av_at = e_av;
    e.wide = e_wide; e.tag = tag;
    sb_q.push_back(e);
    @(posedge clk); #1;
    addr = a; rd = r; hi = h; lo = l; sp = s; lvl = lv;
    as_s = 1'b1; ds_s = !ds_late;
    repeat (18) begin
      @(posedge clk); #1;
      ds_s = 1'b1;
    end
    as_s = 1'b0; ds_s = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  // monitor: k = edges seen with the address strobe
  int k = 0, o_ack = -1, o_av = -1;
  logic [N-1:0] o_cs1 = '1, o_cs2 = '1;
  logic o_wide = 1'b0;
  always @(negedge clk) begin
    if (as_s) begin
      if (k == 1) o_cs1 = cs_n;
      if (k == 2) o_cs2 = cs_n;
      if (ack && o_ack < 0) begin o_ack = k; o_wide = ack_wide; end
      if (autovec && o_av < 0) o_av = k;
      k++;
    end else if (k > 0) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R2", "unexpected cycle", 0, 1);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(o_cs1 == e.cs1, e.tag, "cs_n edge1", int'(o_cs1), int'(e.cs1));
        check(o_cs2 == e.cs2, e.tag, "cs_n edge2", int'(o_cs2), int'(e.cs2));
        check(o_ack == e.ack_at, e.tag, "ack edge", o_ack, e.ack_at);
        check(o_av == e.av_at, e.tag, "autovec edge", o_av, e.av_at);
        if (e.ack_at >= 0)
          check(o_wide == e.wide, e.tag, "ack_wide", int'(o_wide), int'(e.wide));
      end
      k = 0; o_ack = -1; o_av = -1; o_cs1 = '1; o_cs2 = '1; o_wide = 1'b0;
    end
  end

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    report();
  end

  initial begin
    // ch0: 0x000000 64K, both lanes, r/w, user|super, 0 waits, 16-bit
    b[0] = 16'h0003; o[0] = 15'h7830; p[0] = 2'b11;
    // ch1: 0x100000 2K, lower lane, read only, data strobe, 3 waits, super, 8-bit
    b[1] = 16'h1000; o[1] = 15'h2CE0; p[1] = 2'b10;
    // ch2: 0xF00000 1M, CPU space, level 5, fast, autovector, 16-bit
    b[2] = 16'hF007; o[2] = 15'h6B8B; p[2] = 2'b11;
    // ch3: 0x200000 8K, upper lane, write only, user, external term, discrete pin
    b[3] = 16'h2001; o[3] = 15'h53D0; p[3] = 2'b00;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: idle after reset
    check(cs_n == '1, "R1", "cs_n after reset", int'(cs_n), 'hF);
    check(!ack && !autovec && !ack_wide, "R1", "pulses after reset",
          int'({ack, autovec, ack_wide}), 0);

    // R2 R10: inside 64K region, 0 waits -> edge 2, 16-bit
    run_cycle(24'h00ABCD, 1, 1, 1, 2'b01, 0, 0, 4'b1110, 4'b1110, 2, -1, 1, "R2");
    // R2: one byte past the 64K region
    run_cycle(24'h010000, 1, 1, 1, 2'b01, 0, 0, 4'hF, 4'hF, -1, -1, 0, "R2");
    // R2 R9 R10: 2K region, 3 waits -> edge 5, 8-bit
    run_cycle(24'h1007FE, 1, 0, 1, 2'b10, 0, 0, 4'b1101, 4'b1101, 5, -1, 0, "R10");
    // R2: just past the 2K region
    run_cycle(24'h100800, 1, 0, 1, 2'b10, 0, 0, 4'hF, 4'hF, -1, -1, 0, "R2");
    // R7: data strobe one cycle late delays the data-strobe channel
    run_cycle(24'h1007FE, 1, 0, 1, 2'b10, 0, 1, 4'hF, 4'b1101, 5, -1, 0, "R7");
    // R3: upper lane only on a lower-lane channel
    run_cycle(24'h1007FE, 1, 1, 0, 2'b10, 0, 0, 4'hF, 4'hF, -1, -1, 0, "R3");
    // R4: write on a read-only channel
    run_cycle(24'h1007FE, 0, 0, 1, 2'b10, 0, 0, 4'hF, 4'hF, -1, -1, 0, "R4");
    // R5: user cycle on a supervisor channel
    run_cycle(24'h1007FE, 1, 0, 1, 2'b01, 0, 0, 4'hF, 4'hF, -1, -1, 0, "R5");
    // R5: CPU-space cycle never matches a user|super channel
    run_cycle(24'h00ABCD, 1, 1, 1, 2'b00, 5, 0, 4'hF, 4'hF, -1, -1, 0, "R5");
    // R11 R6: level 5 acknowledge -> autovector on edge 1
    run_cycle(24'hF12345, 1, 1, 1, 2'b00, 5, 0, 4'b1011, 4'b1011, -1, 1, 0, "R11");
    // R6: level 3 does not match level field 5
    run_cycle(24'hF12345, 1, 1, 1, 2'b00, 3, 0, 4'hF, 4'hF, -1, -1, 0, "R6");
    @(posedge clk); #1 o[2] = 15'h6B80;   // level 0 = any, no autovector
    run_cycle(24'hF12345, 1, 1, 1, 2'b00, 3, 0, 4'b1011, 4'b1011, 1, -1, 1, "R6");
    // R8: discrete-output pin code keeps select high
    run_cycle(24'h201FFF, 0, 1, 0, 2'b01, 0, 0, 4'hF, 4'hF, -1, -1, 0, "R8");
    @(posedge clk); #1 p[3] = 2'b10;
    // R9: external termination -> select but no pulse
    run_cycle(24'h201FFF, 0, 1, 0, 2'b01, 0, 0, 4'b0111, 4'b0111, -1, -1, 0, "R9");
    @(posedge clk); #1 o[0] = 15'h7B70;   // 13 waits
    run_cycle(24'h000010, 1, 1, 1, 2'b01, 0, 0, 4'b1110, 4'b1110, 15, -1, 1, "R9");
    // R12: overlap ch0 (0 waits, 16-bit) with ch3 (5 waits, 8-bit)
    @(posedge clk); #1;
    o[0] = 15'h7830; b[3] = 16'h0003; o[3] = 15'h7970; p[3] = 2'b10;
    run_cycle(24'h000100, 1, 1, 1, 2'b01, 0, 0, 4'b0110, 4'b0110, 2, -1, 1, "R12");

    repeat (4) @(posedge clk);
    check(sb_q.size() == 0, "R2", "pending items", sb_q.size(), 0);
    report();
  end
endmodule